// File: doc/BRIEF.md
# Dual-Channel Parallel ADC Sequencer

This block is the host-side controller for a dual 12-bit sampling converter with a parallel output bus. Each conversion starts with an active-low start pulse. The block then waits for the converter's busy flag to rise and fall. It opens one active-low chip-select window, and inside that window it issues two active-low read strobes. Each strobe returns one 12-bit word.

The input-pair select line alternates between conversions. The first conversion of a frame digitises the A pair and the second digitises the B pair. The block enforces the settle and setup gaps that must pass before the next start pulse. Every timing value is given in nanoseconds and converted to a whole number of clock cycles, rounded up, from the clock-frequency parameter.

Each word leaves on a valid/ready port with a two-bit tag. A single start pulse runs one A+B frame. Holding the continuous input high repeats frames back to back at the shortest legal spacing. If busy does not complete within a timeout, the block abandons the conversion and raises a sticky error.

Top module: `adc_pair_seq`

## Requirements
- R1: During and right after reset, convst_n_o, cs_n_o and rd_n_o are high, sel_o is low, and out_valid_o and err_o are low.
- R2: Each start pulse holds convst_n_o low for exactly ceil(T_CONVST_NS·CLK_HZ/1e9) cycles. sel_o does not change while convst_n_o is low.
- R3: cs_n_o falls only after busy_i has been seen high and then low, passed through two synchroniser flops. rd_n_o is never low while cs_n_o is high or while busy_i is high. Each window holds exactly two read pulses, and each pulse is low for ceil(T_RD_LO_NS) cycles.
- R4: A word is captured from data_i at the clock edge where rd_n_o rises. The first pulse gives the first word of the pair and the second pulse gives the second word.
- R5: sel_o is low for the first conversion of a frame and high for the second. It changes only at the end of a read window or on an abort, which is while convst_n_o is high.
- R6: From the rise of cs_n_o, or from a change of sel_o, to the next fall of convst_n_o, at least GAP cycles pass. GAP is the larger of ceil(T_SETTLE_NS) and ceil(T_SEL_SETUP_NS). In continuous mode, with the sink always ready, the gap is exactly GAP.
- R7: out_tag_o encodes 0 = A first word, 1 = A second word, 2 = B first word, 3 = B second word. The words of a frame leave in the order 0, 1, 2, 3.
- R8: While out_valid_o is high and out_ready_i is low, out_data_o and out_tag_o hold. No new conversion starts until both words of the previous one have been accepted.
- R9: If busy has not completed within ceil(T_TIMEOUT_NS) cycles of the start fall, the block sets err_o and keeps it set until reset. It never asserts cs_n_o for that conversion, emits no word, and returns sel_o low.
- R10: A start_i pulse in idle with cont_i low runs exactly two conversions (A then B) and then goes idle. With cont_i high, frames repeat. When cont_i drops, the current frame is still completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run one A+B frame when idle |
| cont_i | input | 1 | Repeat frames back to back while high |
| convst_n_o | output | 1 | Active-low conversion start |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| sel_o | output | 1 | Input-pair select, 0 = A, 1 = B |
| busy_i | input | 1 | Converter busy flag, asynchronous |
| data_i | input | 12 | Converter parallel data bus |
| out_valid_o | output | 1 | Result word available |
| out_ready_i | input | 1 | Sink accepts the word |
| out_data_o | output | 12 | Result word |
| out_tag_o | output | 2 | Word tag, see R7 |
| err_o | output | 1 | Sticky busy-timeout flag |

## Verification
The converter model varies how long busy stays high, from a few cycles to most of the timeout, and holds it stuck for the timeout case. A design that read too early would assert a read strobe while busy is still high. A design that never timed out would hang in the stuck case. A design that did not alternate the select line would return B-pair data under an A tag, which the data-dependent word pattern exposes.

The sink is throttled in several ways, including fully stalled. A design that dropped or overwrote a pending word, or that started a new conversion while holding one, shows up in the word sequence and the conversion count. Continuous mode measures the exact start-to-start gap, so a gap that is too short, or one that is padded with extra cycles, is reported.

// File: rtl/adc_pair_seq_pkg.sv
`timescale 1ns/1ps
package adc_pair_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_CONV, S_WAIT_HI, S_WAIT_LO,
        S_RD1_LO, S_RD1_HI, S_RD2_LO, S_GAP
    } seq_state_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_pair_seq_timer.sv
`timescale 1ns/1ps
module adc_pair_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_pair_seq.sv
`timescale 1ns/1ps
module adc_pair_seq
    import adc_pair_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ          = 64'd50_000_000,
    parameter int              DW              = 12,
    parameter longint unsigned T_CONVST_NS     = 64'd60,
    parameter longint unsigned T_RD_LO_NS      = 64'd50,
    parameter longint unsigned T_RD_HI_NS      = 64'd40,
    parameter longint unsigned T_SETTLE_NS     = 64'd300,
    parameter longint unsigned T_SEL_SETUP_NS  = 64'd400,
    parameter longint unsigned T_TIMEOUT_NS    = 64'd4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cont_i,
    output logic          convst_n_o,
    output logic          cs_n_o,
    output logic          rd_n_o,
    output logic          sel_o,
    input  logic          busy_i,
    input  logic [DW-1:0] data_i,
    output logic          out_valid_o,
    input  logic          out_ready_i,
    output logic [DW-1:0] out_data_o,
    output logic [1:0]    out_tag_o,
    output logic          err_o
);
    localparam int unsigned CONV_CYC = ns_to_cyc(T_CONVST_NS, CLK_HZ);
    localparam int unsigned RDLO_CYC = ns_to_cyc(T_RD_LO_NS, CLK_HZ);
    localparam int unsigned RDHI_CYC = ns_to_cyc(T_RD_HI_NS, CLK_HZ);
    localparam int unsigned GAP_CYC  = umax(ns_to_cyc(T_SETTLE_NS, CLK_HZ),
                                            ns_to_cyc(T_SEL_SETUP_NS, CLK_HZ));
    localparam int unsigned TO_CYC   = ns_to_cyc(T_TIMEOUT_NS, CLK_HZ);
    localparam int unsigned PH_MAX   = umax(CONV_CYC, umax(RDLO_CYC, RDHI_CYC));
    localparam int PH_W  = $clog2(PH_MAX + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam int TO_W  = $clog2(TO_CYC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          convst_n;
        logic          cs_n;
        logic          rd_n;
        logic          sel;
        logic          busy_m;
        logic          busy_s;
        logic          ptag;
        logic          err;
        logic [1:0]    pend;
        logic [DW-1:0] w1;
        logic [DW-1:0] w2;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: S_IDLE, convst_n: 1'b1, cs_n: 1'b1, rd_n: 1'b1,
                                 sel: 1'b0, busy_m: 1'b0, busy_s: 1'b0, ptag: 1'b0,
                                 err: 1'b0, pend: 2'd0, w1: '0, w2: '0};

    seq_t d, q;
    logic            ph_load, gap_load, wd_load;
    logic [PH_W-1:0] ph_val;
    logic            ph_done, gap_done, wd_done;
    logic            go_conv, go_abort;

    adc_pair_seq_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load_i(ph_load), .val_i(ph_val), .done_o(ph_done));
    adc_pair_seq_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load_i(gap_load),
        .val_i(GAP_W'(GAP_CYC - 1)), .done_o(gap_done));
    adc_pair_seq_timer #(.W(TO_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .load_i(wd_load),
        .val_i(TO_W'(TO_CYC - 1)), .done_o(wd_done));

    assign out_valid_o = (q.pend != 2'd0);
    assign out_data_o  = (q.pend == 2'd2) ? q.w1 : q.w2;
    assign out_tag_o   = {q.ptag, (q.pend == 2'd1)};

    always_comb begin
        d        = q;
        ph_load  = 1'b0;
        ph_val   = '0;
        gap_load = 1'b0;
        wd_load  = 1'b0;
        go_conv  = 1'b0;
        go_abort = 1'b0;
        d.busy_m = busy_i;
        d.busy_s = q.busy_m;
        if (out_valid_o && out_ready_i) d.pend = q.pend - 2'd1;

        case (q.st)
            S_IDLE:    if (start_i || cont_i) go_conv = 1'b1;
            S_CONV:    if (ph_done) begin
                           d.convst_n = 1'b1;
                           d.st       = S_WAIT_HI;
                       end
            S_WAIT_HI: if (q.busy_s)     d.st = S_WAIT_LO;
                       else if (wd_done) go_abort = 1'b1;
            S_WAIT_LO: if (!q.busy_s) begin
                           d.st    = S_RD1_LO;
                           d.cs_n  = 1'b0;
                           d.rd_n  = 1'b0;
                           ph_load = 1'b1;
                           ph_val  = PH_W'(RDLO_CYC - 1);
                       end else if (wd_done) go_abort = 1'b1;
            S_RD1_LO:  if (ph_done) begin
                           d.rd_n  = 1'b1;
                           d.w1    = data_i;
                           d.st    = S_RD1_HI;
                           ph_load = 1'b1;
                           ph_val  = PH_W'(RDHI_CYC - 1);
                       end
            S_RD1_HI:  if (ph_done) begin
                           d.rd_n  = 1'b0;
                           d.st    = S_RD2_LO;
                           ph_load = 1'b1;
                           ph_val  = PH_W'(RDLO_CYC - 1);
                       end
            S_RD2_LO:  if (ph_done) begin
                           d.rd_n   = 1'b1;
                           d.cs_n   = 1'b1;
                           d.w2     = data_i;
                           d.ptag   = q.sel;
                           d.pend   = 2'd2;
                           d.sel    = ~q.sel;
                           d.st     = S_GAP;
                           gap_load = 1'b1;
                       end
            S_GAP:     if (gap_done && q.pend == 2'd0) begin
                           if (q.sel || cont_i) go_conv = 1'b1;
                           else                 d.st    = S_IDLE;
                       end
            default:   d.st = S_IDLE;
        endcase

        if (go_conv) begin
            d.st       = S_CONV;
            d.convst_n = 1'b0;
            ph_load    = 1'b1;
            ph_val     = PH_W'(CONV_CYC - 1);
            wd_load    = 1'b1;
        end
        if (go_abort) begin
            d.err    = 1'b1;
            d.sel    = 1'b0;
            d.st     = S_GAP;
            gap_load = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign convst_n_o = q.convst_n;
    assign cs_n_o     = q.cs_n;
    assign rd_n_o     = q.rd_n;
    assign sel_o      = q.sel;
    assign err_o      = q.err;

    // cycles since the read window closed, saturating, for the gap check
    logic [GAP_W-1:0] chk_gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           chk_gap_q <= GAP_W'(GAP_CYC);
        else if (!q.cs_n)                     chk_gap_q <= '0;
        else if (chk_gap_q != GAP_W'(GAP_CYC)) chk_gap_q <= chk_gap_q + 1'b1;
    end

    assert_strobe_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rd_n |-> !q.cs_n);
    assert_window_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_n) |-> !$past(q.busy_s));
    assert_sel_held_in_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q.convst_n |-> $stable(q.sel));
    assert_settle_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.convst_n) |-> chk_gap_q >= GAP_W'(GAP_CYC));
    assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o) && $stable(out_tag_o));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);
endmodule

// File: tb/test_adc_pair_seq.sv
`timescale 1ns/1ps
module test_adc_pair_seq;
    localparam int CLK_PERIOD_NS = 20;
    localparam longint unsigned HZ = 64'd1_000_000_000 / CLK_PERIOD_NS;
    localparam int CONV_EXP = (60 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int RDLO_EXP = (50 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int GAP_EXP  = (400 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int TO_EXP   = (4000 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    // frame vectors: {busy length in cycles, sink ready pattern}
    localparam logic [9:0] FRAMES [4] = '{
        {8'd150, 2'd0}, {8'd20, 2'd1}, {8'd60, 2'd2}, {8'd5, 2'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cont = 1'b0;
    logic convst_n, cs_n, rd_n, sel, busy = 1'b0, out_valid, out_ready = 1'b1, err;
    logic [11:0] data = '0, out_data;
    logic [1:0]  out_tag;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rmode = 0, busy_len = 150;
    bit stuck = 1'b0;
    int conv_cnt = 0, cs_falls = 0, nwords = 0, last_gap = 0;
    logic [11:0] got_data [128];
    logic [1:0]  got_tag  [128];

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    adc_pair_seq #(.CLK_HZ(HZ)) i_adc_pair_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
        .convst_n_o(convst_n), .cs_n_o(cs_n), .rd_n_o(rd_n), .sel_o(sel),
        .busy_i(busy), .data_i(data), .out_valid_o(out_valid), .out_ready_i(out_ready),
        .out_data_o(out_data), .out_tag_o(out_tag), .err_o(err));

    function automatic logic [11:0] fdat(int k, int s, int i);
        return 12'((k * 97 + s * 1500 + i * 700 + 291) % 4096);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model
    initial begin
        int m_k = 0, m_sel = 0, m_idx = 0, m_bcnt = 0;
        logic m_pcv = 1'b1, m_prd = 1'b1;
        forever begin
            @(posedge clk); #2;
            if (!convst_n && m_pcv) begin
                conv_cnt++;
                m_k = conv_cnt - 1; m_sel = int'(sel);
                busy = 1'b1; m_bcnt = busy_len;
            end else if (busy && !stuck) begin
                if (m_bcnt <= 1) busy = 1'b0; else m_bcnt--;
            end
            m_pcv = convst_n;
            if (cs_n) m_idx = 0;
            else if (rd_n && !m_prd) m_idx++;
            m_prd = rd_n;
            data = fdat(m_k, m_sel, m_idx);
        end
    end

    // sink ready pattern
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        case (rmode)
            0: out_ready = 1'b1;
            1: out_ready = cyc[0];
            2: out_ready = (cyc % 7 == 0);
            default: out_ready = 1'b0;
        endcase
    end

    // port monitors and word collector
    initial begin
        int cv_run = 0, rd_run = 0, since_cs = 1000, since_sel = 1000;
        logic p_cv = 1'b1, p_cs = 1'b1, p_rd = 1'b1, p_sel = 1'b0, p_hold = 1'b0;
        logic [11:0] p_dat = '0;
        logic [1:0]  p_tag = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                since_cs++; since_sel++;
                if (!convst_n) begin
                    cv_run++;
                    if (sel != p_sel) chk(0, "R2 sel moved during start", int'(sel), int'(p_sel));
                end else if (!p_cv) begin
                    chk(cv_run == CONV_EXP, "R2 start width", cv_run, CONV_EXP);
                    cv_run = 0;
                end
                if (!convst_n && p_cv) begin
                    last_gap = since_cs;
                    chk(since_cs >= GAP_EXP, "R6 read-to-start gap", since_cs, GAP_EXP);
                    chk(since_sel >= GAP_EXP, "R5 sel setup", since_sel, GAP_EXP);
                end
                if (!rd_n) begin
                    rd_run++;
                    if (cs_n) chk(0, "R3 strobe outside window", 1, 0);
                    if (busy) chk(0, "R3 strobe while busy", 1, 0);
                end else if (!p_rd) begin
                    chk(rd_run == RDLO_EXP, "R3 strobe width", rd_run, RDLO_EXP);
                    rd_run = 0;
                end
                if (!cs_n && p_cs) cs_falls++;
                if (cs_n && !p_cs) since_cs = 0;
                if (sel != p_sel) since_sel = 0;
                if (p_hold)
                    chk(out_valid && out_data == p_dat && out_tag == p_tag,
                        "R8 hold while stalled", int'(out_data), int'(p_dat));
                p_hold = out_valid && !out_ready;
                p_dat = out_data; p_tag = out_tag;
                if (out_valid && out_ready && nwords < 128) begin
                    got_data[nwords] = out_data;
                    got_tag[nwords]  = out_tag;
                    nwords++;
                end
            end
            p_cv = convst_n; p_cs = cs_n; p_rd = rd_n; p_sel = sel;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_words(int n, int limit);
        for (int i = 0; i < limit && nwords < n; i++) @(negedge clk);
    endtask

    task automatic check_frame(int base, int k0, string req);
        for (int j = 0; j < 4; j++) begin
            chk(got_tag[base + j] == 2'(j), {req, " R7 tag order"}, int'(got_tag[base + j]), j);
            chk(got_data[base + j] == fdat(k0 + j / 2, j / 2, j % 2), {req, " R4 word value"},
                int'(got_data[base + j]), int'(fdat(k0 + j / 2, j / 2, j % 2)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(convst_n && cs_n && rd_n, "R1 strobes idle in reset", int'({convst_n, cs_n, rd_n}), 7);
        chk(!sel && !out_valid && !err, "R1 sel/valid/err low in reset", int'({sel, out_valid, err}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(convst_n && cs_n && rd_n, "R1 strobes idle after reset", int'({convst_n, cs_n, rd_n}), 7);
        chk(!sel && !out_valid && !err, "R1 outputs low after reset", int'({sel, out_valid, err}), 0);

        for (int i = 0; i < 4; i++) begin
            int base, k0;
            busy_len = int'(FRAMES[i][9:2]);
            rmode    = int'(FRAMES[i][1:0]);
            base = nwords; k0 = conv_cnt;
            pulse_start();
            wait_words(base + 4, 3000);
            repeat (80) @(negedge clk);
            chk(nwords == base + 4, "R10 four words per frame", nwords - base, 4);
            chk(conv_cnt == k0 + 2, "R10 two conversions per frame", conv_cnt - k0, 2);
            check_frame(base, k0, "vector");
        end

        begin : stall_test
            int base, k0;
            rmode = 3; busy_len = 30; base = nwords; k0 = conv_cnt;
            pulse_start();
            repeat (600) @(negedge clk);
            chk(conv_cnt == k0 + 1, "R8 no new start while words pending", conv_cnt - k0, 1);
            chk(out_valid && out_tag == 2'd0, "R8 first word offered", int'(out_tag), 0);
            rmode = 0;
            wait_words(base + 4, 3000);
            repeat (40) @(negedge clk);
            check_frame(base, k0, "stall");
        end

        begin : cont_test
            int base, k0;
            rmode = 0; busy_len = 20; base = nwords; k0 = conv_cnt;
            @(posedge clk); #1 cont = 1'b1;
            wait_words(base + 8, 5000);
            @(posedge clk); #1 cont = 1'b0;
            repeat (1000) @(negedge clk);
            chk((nwords - base) % 4 == 0, "R10 frame completes after cont drops", (nwords - base) % 4, 0);
            check_frame(base, k0, "cont 1");
            check_frame(base + 4, k0 + 2, "cont 2");
            chk(last_gap == GAP_EXP, "R6 exact gap in continuous mode", last_gap, GAP_EXP);
        end

        begin : timeout_test
            int base, k0, csf;
            stuck = 1'b1; busy_len = 20; base = nwords; k0 = conv_cnt; csf = cs_falls;
            pulse_start();
            repeat (TO_EXP + 100) @(negedge clk);
            chk(err == 1'b1, "R9 error raised on timeout", int'(err), 1);
            chk(cs_falls == csf, "R9 no read window on timeout", cs_falls - csf, 0);
            chk(nwords == base, "R9 no words on timeout", nwords - base, 0);
            chk(sel == 1'b0, "R9 sel back to A", int'(sel), 0);
            chk(conv_cnt == k0 + 1, "R9 no retry when not continuous", conv_cnt - k0, 1);
            stuck = 1'b0;
            repeat (200) @(negedge clk);
            base = nwords; k0 = conv_cnt;
            pulse_start();
            wait_words(base + 4, 3000);
            repeat (40) @(negedge clk);
            check_frame(base, k0, "after timeout");
            chk(err == 1'b1, "R9 error stays set", int'(err), 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule